// File: doc/BRIEF.md
# External Breakpoint Stop Controller

This block gathers breakpoint requests that originate outside the processor core and decides in which cycle the core is asked to halt. Requests come from a parameterised group of on-chip peripheral request lines and from two sticky bits set through the debug port. One of these bits is maskable and the other is not. Peripheral lines and the maskable debug bit feed a shared maskable request. The non-maskable debug bit feeds a separate request that ignores the machine state.

External requests are not bound to a particular instruction. A request is held pending until an instruction that used the load/store bus completes, and that completion is signalled by a one-cycle strobe. A maskable request is honoured only while the core reports a recoverable state; otherwise it waits. A non-maskable request is honoured at the next completion whatever the state. When it is taken while the state is not recoverable, a second output tells the debug logic that machine context may have been lost.

The stop request is a registered one-cycle pulse. It appears in the cycle after the clock edge at which the qualifying completion strobe is sampled.

Top module: `ext_brk_mask_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `stop_req` and `stop_nonrecov` are 0. Requests logged before reset are discarded.
- R2: A debug-port bit (`dport_mask` or `dport_nmask`) logs a request only on a 0-to-1 change between two sampled clock edges. Keeping it at 1 logs nothing more.
- R3: A debug-port bit that has gone back to 0 and then to 1 again logs a new request.
- R4: `stop_req` goes high only in the cycle after an edge where `ls_done` was 1. Without `ls_done`, a request stays pending for any number of cycles.
- R5: A request that is logged on the same edge as an `ls_done` strobe is taken by that strobe.
- R6: A maskable request is taken only on an edge where both `ls_done` and `recov` are 1. It stays pending across strobes seen with `recov` at 0.
- R7: A non-maskable request is taken at the next `ls_done` edge regardless of `recov`. `stop_nonrecov` is 1 exactly when `recov` was 0 on that edge.
- R8: Any `periph_req` line that is 1 on an edge logs a maskable request.
- R9: When both request types are pending, a single stop is issued under the non-maskable rules. The pending maskable request is cleared with it.
- R10: Every take clears all pending requests. A later `ls_done` with no new request gives no stop, so `stop_req` lasts one cycle for each take.
- R11: `stop_nonrecov` is never 1 while `stop_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_req | input | PERIPH_W | Maskable breakpoint requests from peripherals, 1 = request |
| dport_mask | input | 1 | Sticky maskable debug-port bit, acts on its rising change |
| dport_nmask | input | 1 | Sticky non-maskable debug-port bit, acts on its rising change |
| recov | input | 1 | Core is in a recoverable state |
| ls_done | input | 1 | One-cycle strobe: a load/store-bus instruction completed |
| stop_req | output | 1 | Registered one-cycle halt request |
| stop_nonrecov | output | 1 | Halt was taken while the state was not recoverable |

## Verification
The bench builds the block with `PERIPH_W` = 3 rather than the default of 4. The three lines can then be driven one at a time, so a request on the lowest, middle and highest line each reaches the shared maskable path, in isolation and together with other requests. With this width every peripheral line gets its own vector while the vector table stays short. The table covers strobe timing, held and re-raised debug bits, and collisions between the two request types under both values of `recov`.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
  typedef struct packed {
    logic nmask;
    logic mask;
  } brk_req_t;
endpackage

// File: rtl/ebm_edge_det.sv
module ebm_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign rise[g] = lvl[g] & ~prev_q[g];

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
      rise[g] |=> !rise[g]);
  end
endmodule

// File: rtl/ebm_pending.sv
module ebm_pending
  import ebm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  brk_req_t new_req,
  input  logic     take,
  output brk_req_t eff_req
);
  brk_req_t pend_q;

  assign eff_req.mask  = pend_q.mask  | new_req.mask;
  assign eff_req.nmask = pend_q.nmask | new_req.nmask;

  always_ff @(posedge clk) begin
    if (rst || take) pend_q <= '0;
    else             pend_q <= eff_req;
  end

  // R10
  cleared_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (pend_q == '0));
endmodule

// File: rtl/ebm_arbiter.sv
module ebm_arbiter
  import ebm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  brk_req_t eff_req,
  input  logic     recov,
  input  logic     ls_done,
  output logic     take,
  output logic     stop_req,
  output logic     stop_nonrecov
);
  logic nm_take;
  logic m_take;

  assign nm_take = ls_done & eff_req.nmask;
  assign m_take  = ls_done & eff_req.mask & recov;
  assign take    = nm_take | m_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_req      <= 1'b0;
      stop_nonrecov <= 1'b0;
    end else begin
      stop_req      <= take;
      stop_nonrecov <= nm_take & ~recov;
    end
  end

  // R4
  stop_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    stop_req |-> $past(ls_done));
endmodule

// File: rtl/ext_brk_mask_ctrl.sv
module ext_brk_mask_ctrl
  import ebm_pkg::*;
#(
  parameter int PERIPH_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIPH_W-1:0] periph_req,
  input  logic                dport_mask,
  input  logic                dport_nmask,
  input  logic                recov,
  input  logic                ls_done,
  output logic                stop_req,
  output logic                stop_nonrecov
);
  localparam int DBG_W = 2;

  logic [DBG_W-1:0] dbg_rise;
  brk_req_t         new_req;
  brk_req_t         eff_req;
  logic             take;

  ebm_edge_det #(.W(DBG_W)) edge_i (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({dport_nmask, dport_mask}),
    .rise (dbg_rise)
  );

  assign new_req.mask  = dbg_rise[0] | (|periph_req);
  assign new_req.nmask = dbg_rise[1];

  ebm_pending pend_i (
    .clk     (clk),
    .rst     (rst),
    .new_req (new_req),
    .take    (take),
    .eff_req (eff_req)
  );

  ebm_arbiter arb_i (
    .clk           (clk),
    .rst           (rst),
    .eff_req       (eff_req),
    .recov         (recov),
    .ls_done       (ls_done),
    .take          (take),
    .stop_req      (stop_req),
    .stop_nonrecov (stop_nonrecov)
  );

  // R11
  nonrecov_with_stop_chk: assert property (@(posedge clk) disable iff (rst)
    stop_nonrecov |-> stop_req);

  // R6
  masked_needs_recov_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !stop_nonrecov) |-> $past(recov));
endmodule

// File: tb/ext_brk_mask_ctrl_tb.sv
module ext_brk_mask_ctrl_tb_top;
  localparam int PW = 3;
  localparam int NV = 23;

  logic          clk = 1'b0;
  logic          rst;
  logic [PW-1:0] periph_req;
  logic          dport_mask, dport_nmask, recov, ls_done;
  logic          stop_req, stop_nonrecov;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done_run = 1'b0;

  always #2 clk = ~clk;

  ext_brk_mask_ctrl #(.PERIPH_W(PW)) dut_i (
    .clk(clk), .rst(rst), .periph_req(periph_req),
    .dport_mask(dport_mask), .dport_nmask(dport_nmask),
    .recov(recov), .ls_done(ls_done),
    .stop_req(stop_req), .stop_nonrecov(stop_nonrecov)
  );

  // bits: [8:6] periph, [5] dport_mask, [4] dport_nmask, [3] recov, [2] ls_done,
  //       [1] expected stop_req, [0] expected stop_nonrecov
  localparam logic [8:0] VEC [NV] = '{
    9'b000_0_0_1_0_0_0, // 0  idle
    9'b000_1_0_1_0_0_0, // 1  R4 rise logged, no strobe
    9'b000_1_0_1_0_0_0, // 2  R4 still waiting
    9'b000_1_0_1_1_1_0, // 3  R4 taken on strobe
    9'b000_1_0_1_1_0_0, // 4  R2 R10 held bit, no retrigger
    9'b000_0_0_1_1_0_0, // 5  cleared
    9'b000_1_0_1_1_1_0, // 6  R3 R5 set again with strobe
    9'b000_1_0_0_0_0_0, // 7
    9'b000_0_0_0_0_0_0, // 8
    9'b000_1_0_0_1_0_0, // 9  R6 strobe while not recoverable
    9'b000_1_0_0_1_0_0, // 10 R6 still pending
    9'b000_1_0_1_0_0_0, // 11 R6 recoverable, no strobe
    9'b000_1_0_1_1_1_0, // 12 R6 taken
    9'b000_0_1_0_0_0_0, // 13 R7 non-maskable logged
    9'b000_0_1_0_1_1_1, // 14 R7 taken, not recoverable
    9'b000_0_0_1_1_0_0, // 15 R10
    9'b000_0_1_1_1_1_0, // 16 R5 R7 taken, recoverable
    9'b010_0_0_1_0_0_0, // 17 R8 middle line
    9'b000_0_0_1_1_1_0, // 18 R8 taken
    9'b100_0_0_0_0_0_0, // 19 R8 high line, not recoverable
    9'b000_0_1_0_1_1_1, // 20 R9 both pending, non-maskable wins
    9'b000_0_0_1_1_0_0, // 21 R9 R10 maskable cleared too
    9'b001_0_0_1_1_1_0  // 22 R5 R8 low line with strobe
  };

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [PW-1:0] p, input logic dm, input logic dn,
                       input logic r, input logic d);
    @(negedge clk);
    periph_req = p; dport_mask = dm; dport_nmask = dn; recov = r; ls_done = d;
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (stop_nonrecov && !stop_req && !rst) begin
      n_bad++;
      $display("FAIL R11 nonrecov without stop: actual 1 expected 0");
    end
  end

  initial begin
    #40000;
    if (!done_run) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; periph_req = '0; dport_mask = 0; dport_nmask = 0; recov = 0; ls_done = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", stop_req, 1'b0, "stop in reset");
    chk("R1", stop_nonrecov, 1'b0, "nonrecov in reset");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", stop_req, 1'b0, "stop after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][8:6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      chk($sformatf("R-vec%0d", i), stop_req, VEC[i][1], "stop_req");
      chk($sformatf("R-vec%0d", i), stop_nonrecov, VEC[i][0], "stop_nonrecov");
    end

    // R1: pending request discarded by reset
    drive('0, 1'b0, 1'b0, 1'b1, 1'b0);
    drive('0, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1; dport_nmask = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    drive('0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R1", stop_req, 1'b0, "pending cleared by reset");

    // R4: long wait without strobe
    drive('0, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 20; k++) begin
      drive('0, 1'b0, 1'b1, 1'b1, 1'b0);
      chk("R4", stop_req, 1'b0, "no stop without strobe");
    end
    drive('0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R4", stop_req, 1'b1, "stop on late strobe");
    drive('0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R10", stop_req, 1'b0, "pulse one cycle");

    // R6: maskable held across many strobes while not recoverable
    drive('0, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      drive('0, 1'b1, 1'b0, 1'b0, 1'b1);
      chk("R6", stop_req, 1'b0, "masked while not recoverable");
    end
    drive('0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6", stop_req, 1'b1, "taken once recoverable");
    chk("R6", stop_nonrecov, 1'b0, "maskable stop is recoverable");

    done_run = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule